// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block decides, for every received Ethernet frame, whether the frame is kept or discarded. The decision depends only on the 48-bit destination address that opens the frame. Received bytes arrive one per cycle on a byte-wide stream. A start-of-frame flag marks the first byte, and a valid flag qualifies every byte. A simple register write port programs the filter. The programmed settings are the mode bits, a 64-bin multicast hash table and a small table of exact-match unicast addresses.

While the address streams in, the block updates a reflected CRC-32 one byte per cycle. It also captures the address bytes. On the edge that takes in the sixth address byte, it folds that byte into the CRC, looks up the hash bin and compares against every exact-match entry. It then registers a one-cycle decision strobe together with an accept flag.

Register writes land in a shadow copy of the settings. The shadow copy becomes the working copy only when a new frame starts, so a single decision never mixes old and new settings. Software that needs more unicast addresses than the table holds is expected to turn on promiscuous mode instead.

Top module: `dst_addr_filter`

## Requirements
- R1: When the promiscuous bit (bit 0 of the mode register at address 0) is set, every frame is accepted.
- R2: A destination of all ones is accepted under every mode setting.
- R3: When the pass-all-multicast bit (bit 1 of the mode register) is set, any multicast destination is accepted without any hash lookup. A destination is multicast when bit 0 of its first byte is 1.
- R4: When the hash bit (bit 2 of the mode register) is set, a multicast destination is accepted if its bin is set. The bin index is found as follows. A reflected CRC-32 with polynomial 0xEDB88320, preset to all ones, runs over the six address bytes, first byte first and least significant bit first. The result is complemented and bit-reversed, and the index is the top six bits of that value. Bins 0 to 31 are bits 0 to 31 of the register at address 1. Bins 32 to 63 are bits 0 to 31 of the register at address 2.
- R5: A multicast destination other than all ones is dropped when the pass-all-multicast bit is clear and either the hash bit is clear or its bin is clear.
- R6: Exact-match entry i has a low register at address 4+2i and a high register at address 5+2i. The low register holds address bytes 0 to 3, with byte 0 in bits 7:0. The high register holds bytes 4 and 5 in bits 15:0 and an enable flag in bit 31. A unicast destination equal to any enabled entry is accepted. A disabled entry never matches.
- R7: A unicast destination that equals no enabled entry is dropped unless the promiscuous bit is set.
- R8: After reset, the decision strobe and the accept flag are low. The strobe is high for exactly one cycle: the cycle that follows the clock edge sampling the sixth address byte. The accept flag is high only together with the strobe.
- R9: A register write takes effect at the next start of frame. A write made while a frame's address is arriving does not change that frame's decision.
- R10: Bytes count only while valid is high, so gaps are allowed. Bytes after the sixth are ignored until the next start of frame. A start of frame in the middle of an address restarts the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Marks the first byte of a frame; only counts when rx_valid is high |
| rx_valid | input | 1 | The byte on rx_byte is valid this cycle |
| rx_byte | input | 8 | Received byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted; meaningful only with dec_valid |

## Verification
The hash path is the hardest to reach from the ports. A bin is a CRC of the whole address, so choosing an address does not control which bin it lands in. The bench computes the bin of each candidate address arithmetically. For every one of the 64 bins it sets only that bin in the table and searches out an address that falls in it. It then sends that address together with several addresses that fall elsewhere. A second difficult case is a register write that lands in the middle of an address. The bench asserts the write port on the third address byte of a frame and checks that the frame is judged under the old settings and the next frame under the new ones.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int unsigned BYTES_PER_ADDR = 6;
    localparam int unsigned MAC_W          = 8 * BYTES_PER_ADDR;
    localparam int unsigned CRC_W          = 32;
    localparam int unsigned HASH_BINS      = 64;
    localparam int unsigned HASH_IDX_W     = $clog2(HASH_BINS);
    localparam int unsigned REG_W          = 32;
    localparam logic [CRC_W-1:0] CRC_POLY  = 32'hEDB8_8320;

    // register word addresses
    localparam int unsigned REG_MODE       = 0;
    localparam int unsigned REG_HASH_LO    = 1;
    localparam int unsigned REG_HASH_HI    = 2;
    localparam int unsigned REG_ENTRY_BASE = 4;

    // bit positions
    localparam int unsigned MODE_PROMISC_BIT = 0;
    localparam int unsigned MODE_ALLMC_BIT   = 1;
    localparam int unsigned MODE_HASH_BIT    = 2;
    localparam int unsigned ENTRY_EN_BIT     = 31;

    typedef struct packed {
        logic                 promisc;
        logic                 all_mcast;
        logic                 hash_en;
        logic [HASH_BINS-1:0] hash;
    } filt_mode_t;

    // one byte of a reflected CRC, least significant data bit first
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] crc_in,
                                                       input logic [7:0]       data);
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
    import daf_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4,
    parameter int unsigned REG_AW      = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [REG_AW-1:0]                    wr_addr,
    input  logic [REG_W-1:0]                     wr_data,
    input  logic                                 load,
    output filt_mode_t                           act_mode,
    output logic [NUM_ENTRIES-1:0]               act_en,
    output logic [NUM_ENTRIES-1:0][MAC_W-1:0]    act_mac
);

    localparam int unsigned HALF_BINS = HASH_BINS / 2;
    localparam int unsigned HI_BYTES_W = MAC_W - REG_W;

    typedef struct packed {
        filt_mode_t                         mode;
        logic [NUM_ENTRIES-1:0]             en;
        logic [NUM_ENTRIES-1:0][MAC_W-1:0]  mac;
    } bank_t;

    typedef struct packed {
        bank_t shadow;
        bank_t active;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == REG_AW'(REG_MODE)) begin
                st_d.shadow.mode.promisc   = wr_data[MODE_PROMISC_BIT];
                st_d.shadow.mode.all_mcast = wr_data[MODE_ALLMC_BIT];
                st_d.shadow.mode.hash_en   = wr_data[MODE_HASH_BIT];
            end
            if (wr_addr == REG_AW'(REG_HASH_LO))
                st_d.shadow.mode.hash[HALF_BINS-1:0] = wr_data;
            if (wr_addr == REG_AW'(REG_HASH_HI))
                st_d.shadow.mode.hash[HASH_BINS-1:HALF_BINS] = wr_data;
            for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
                if (wr_addr == REG_AW'(REG_ENTRY_BASE + 2 * i))
                    st_d.shadow.mac[i][REG_W-1:0] = wr_data;
                if (wr_addr == REG_AW'(REG_ENTRY_BASE + 2 * i + 1)) begin
                    st_d.shadow.mac[i][MAC_W-1:REG_W] = wr_data[HI_BYTES_W-1:0];
                    st_d.shadow.en[i]                 = wr_data[ENTRY_EN_BIT];
                end
            end
        end
        // the working copy follows the shadow copy only at frame start
        if (load) st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_mode = st_q.active.mode;
    assign act_en   = st_q.active.en;
    assign act_mac  = st_q.active.mac;

    assert_active_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.active));

    assert_load_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.active == $past(st_q.shadow)));

endmodule

// File: rtl/daf_crc_hash.sv
module daf_crc_hash
    import daf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  step,
    input  logic [7:0]            data,
    output logic [CRC_W-1:0]      crc_next,
    output logic [HASH_IDX_W-1:0] bin_idx
);

    logic [CRC_W-1:0] crc_d, crc_q;
    logic [CRC_W-1:0] base;

    always_comb begin
        base     = start ? '1 : crc_q;
        crc_next = crc_step_byte(base, data);
        crc_d    = step ? crc_next : crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    // complement, reverse, keep top bits: index bit (W-1-j) is ~crc bit j
    for (genvar j = 0; j < int'(HASH_IDX_W); j++) begin : g_bin
        assign bin_idx[HASH_IDX_W-1-j] = ~crc_next[j];
    end

    assert_crc_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(crc_q));

endmodule

// File: rtl/daf_perfect_match.sv
module daf_perfect_match
    import daf_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4
) (
    input  logic [MAC_W-1:0]                   mac_in,
    input  logic [NUM_ENTRIES-1:0]             entry_en,
    input  logic [NUM_ENTRIES-1:0][MAC_W-1:0]  entry_mac,
    output logic                               hit
);

    logic [NUM_ENTRIES-1:0] match;

    for (genvar i = 0; i < int'(NUM_ENTRIES); i++) begin : g_entry
        assign match[i] = entry_en[i] && (entry_mac[i] == mac_in);
    end

    assign hit = |match;

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4,
    parameter int unsigned REG_AW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              dec_valid,
    output logic              dec_accept
);

    localparam int unsigned CNT_W = $clog2(BYTES_PER_ADDR + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [MAC_W-1:0] mac;
        logic             dv;
        logic             acc;
    } flt_state_t;

    flt_state_t st_d, st_q;

    filt_mode_t                         act_mode;
    logic [NUM_ENTRIES-1:0]             act_en;
    logic [NUM_ENTRIES-1:0][MAC_W-1:0]  act_mac;
    logic                               frame_start;
    logic                               taking;
    logic                               last;
    logic [CNT_W-1:0]                   pos;
    logic [MAC_W-1:0]                   mac_nx;
    logic [CRC_W-1:0]                   crc_next;
    logic [HASH_IDX_W-1:0]              bin_idx;
    logic                               uc_hit;
    logic                               accept;

    assign frame_start = rx_valid && rx_sof;

    daf_cfg_regs #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .REG_AW      (REG_AW)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .load     (frame_start),
        .act_mode (act_mode),
        .act_en   (act_en),
        .act_mac  (act_mac)
    );

    daf_crc_hash crc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rx_sof),
        .step     (taking),
        .data     (rx_byte),
        .crc_next (crc_next),
        .bin_idx  (bin_idx)
    );

    daf_perfect_match #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) pm_i (
        .mac_in    (mac_nx),
        .entry_en  (act_en),
        .entry_mac (act_mac),
        .hit       (uc_hit)
    );

    always_comb begin
        st_d   = st_q;
        pos    = rx_sof ? '0 : st_q.cnt;
        taking = rx_valid && (rx_sof ||
                 (st_q.cnt != '0 && st_q.cnt < CNT_W'(BYTES_PER_ADDR)));
        mac_nx = st_q.mac;
        if (taking) mac_nx[8 * int'(pos) +: 8] = rx_byte;
        last   = taking && (pos == CNT_W'(BYTES_PER_ADDR - 1));

        if (act_mode.promisc || (&mac_nx))
            accept = 1'b1;
        else if (mac_nx[0])
            accept = act_mode.all_mcast || (act_mode.hash_en && act_mode.hash[bin_idx]);
        else
            accept = uc_hit;

        if (taking) st_d.cnt = pos + CNT_W'(1);
        st_d.mac = mac_nx;
        st_d.dv  = last;
        st_d.acc = last && accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid  = st_q.dv;
    assign dec_accept = st_q.acc;

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_strobe_follows_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));

    assert_accept_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    assert_promisc_accepts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && act_mode.promisc) |-> dec_accept);

    assert_broadcast_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&st_q.mac)) |-> dec_accept);

    assert_allmc_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && st_q.mac[0] && act_mode.all_mcast) |-> dec_accept);

    assert_mcast_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && st_q.mac[0] && !(&st_q.mac) && !act_mode.promisc &&
         !act_mode.all_mcast && !act_mode.hash_en) |-> !dec_accept);

endmodule

// File: tb/dst_addr_filter_tb_top.sv
module dst_addr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM        = 4;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_sof = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          dec_valid;
    logic          dec_accept;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the settings
    logic [2:0]  sh_mode = '0;
    logic [63:0] sh_hash = '0;
    logic [47:0] sh_mac [NUM];
    logic [NUM-1:0] sh_en = '0;
    logic [2:0]  ac_mode = '0;
    logic [63:0] ac_hash = '0;
    logic [47:0] ac_mac [NUM];
    logic [NUM-1:0] ac_en = '0;

    dst_addr_filter #(.NUM_ENTRIES(NUM), .REG_AW(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_sof     (rx_sof),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            summary();
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int hash_bin(input logic [47:0] d);
        logic [31:0] c;
        logic [31:0] r;
        logic fb;
        c = '1;
        for (int k = 0; k < 48; k++) begin
            fb = c[0] ^ d[k];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        c = ~c;
        for (int j = 0; j < 32; j++) r[31-j] = c[j];
        return int'(r[31:26]);
    endfunction

    function automatic logic model_accept(input logic [47:0] d);
        if (ac_mode[0] || (&d)) return 1'b1;
        if (d[0]) return ac_mode[1] || (ac_mode[2] && ac_hash[hash_bin(d)]);
        for (int i = 0; i < NUM; i++)
            if (ac_en[i] && ac_mac[i] == d) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(input logic [47:0] d);
        if (ac_mode[0]) return "R1";
        if (&d) return "R2";
        if (d[0]) begin
            if (ac_mode[1]) return "R3";
            if (ac_mode[2] && ac_hash[hash_bin(d)]) return "R4";
            return "R5";
        end
        for (int i = 0; i < NUM; i++)
            if (ac_en[i] && ac_mac[i] == d) return "R6";
        return "R7";
    endfunction

    task automatic apply_write(input int a, input logic [31:0] v);
        if (a == 0) sh_mode = v[2:0];
        else if (a == 1) sh_hash[31:0] = v;
        else if (a == 2) sh_hash[63:32] = v;
        else if (a >= 4 && a < 4 + 2 * NUM) begin
            if (a % 2 == 0) sh_mac[(a - 4) / 2][31:0] = v;
            else begin
                sh_mac[(a - 4) / 2][47:32] = v[15:0];
                sh_en[(a - 4) / 2]         = v[31];
            end
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = AW'(a);
        reg_wdata = v;
        apply_write(a, v);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic copy_active();
        ac_mode = sh_mode;
        ac_hash = sh_hash;
        ac_en   = sh_en;
        for (int i = 0; i < NUM; i++) ac_mac[i] = sh_mac[i];
    endtask

    // send one address; gap idle cycles between bytes, extra trailing bytes,
    // optional register write on byte index mw_at
    task automatic send(input logic [47:0] d, input int gap, input int extra,
                        input int mw_at, input int mw_addr, input logic [31:0] mw_data,
                        input string force_tag);
        logic early;
        logic got_dv;
        logic got_acc;
        logic exp;
        string tag;
        early = 1'b0;
        got_dv = 1'b0;
        got_acc = 1'b0;
        exp = 1'b0;
        tag = "";
        for (int k = 0; k < 6 + extra; k++) begin
            if (k > 0 && k < 6) begin
                repeat (gap) begin
                    @(negedge clk);
                    if (dec_valid) early = 1'b1;
                    rx_valid = 1'b0;
                    rx_sof = 1'b0;
                    reg_we = 1'b0;
                end
            end
            @(negedge clk);
            if (k == 6) begin
                got_dv = dec_valid;
                got_acc = dec_accept;
            end else if (dec_valid) early = 1'b1;
            reg_we = 1'b0;
            if (k == 0) begin
                copy_active();
                exp = model_accept(d);
                tag = (force_tag != "") ? force_tag : tag_of(d);
            end
            if (k == mw_at) begin
                reg_we = 1'b1;
                reg_addr = AW'(mw_addr);
                reg_wdata = mw_data;
                apply_write(mw_addr, mw_data);
            end
            rx_valid = 1'b1;
            rx_sof = (k == 0);
            rx_byte = (k < 6) ? d[8*k +: 8] : 8'(k * 29 + 3);
        end
        @(negedge clk);
        if (extra == 0) begin
            got_dv = dec_valid;
            got_acc = dec_accept;
        end else if (dec_valid) early = 1'b1;
        rx_valid = 1'b0;
        rx_sof = 1'b0;
        reg_we = 1'b0;
        @(negedge clk);
        if (dec_valid) early = 1'b1;
        chk(got_dv && !early, 1'b1, (extra > 0 || gap > 0) ? "R10" : "R8", "single strobe after sixth byte");
        chk(got_acc, exp, tag, $sformatf("decision for %012h", d));
    endtask

    task automatic partial(input logic [47:0] d, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (k == 0);
            rx_byte = d[8*k +: 8];
        end
    endtask

    localparam logic [47:0] STATION = 48'h5544_3322_1100;
    localparam logic [47:0] EXTRA1  = 48'hA1B2_C3D4_E5F6;
    localparam logic [47:0] DISABLD = 48'h0000_0000_0002;
    localparam logic [47:0] STRANGR = 48'h1122_3344_5566;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    initial begin
        logic [47:0] addrs [9];
        logic [47:0] cand;
        for (int i = 0; i < NUM; i++) begin
            sh_mac[i] = '0;
            ac_mac[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_valid, 1'b0, "R8", "strobe after reset");
        chk(dec_accept, 1'b0, "R8", "accept after reset");

        // exact-match table (R6)
        wr(4, STATION[31:0]);  wr(5, {1'b1, 15'd0, STATION[47:32]});
        wr(6, EXTRA1[31:0]);   wr(7, {1'b1, 15'd0, EXTRA1[47:32]});
        wr(8, DISABLD[31:0]);  wr(9, {1'b0, 15'd0, DISABLD[47:32]});
        wr(1, 32'hA5A5_3C3C);  wr(2, 32'h8421_0F0F);

        addrs[0] = STATION; addrs[1] = EXTRA1; addrs[2] = DISABLD; addrs[3] = STRANGR;
        addrs[4] = BCAST;   addrs[5] = 48'h0000_0000_0001; addrs[6] = 48'h1234_5678_9A01;
        addrs[7] = 48'hFEDC_BA98_7633; addrs[8] = 48'h0180_C200_0001;

        // every mode combination against every address class (R1-R7)
        for (int m = 0; m < 8; m++) begin
            wr(0, 32'(m));
            for (int a = 0; a < 9; a++) send(addrs[a], 0, 0, -1, 0, 0, "");
        end

        // every hash bin with a one-hot table (R4, R5)
        wr(0, 32'h4);
        for (int b = 0; b < 64; b++) begin
            wr(1, (b < 32) ? (32'h1 << b) : 32'h0);
            wr(2, (b >= 32) ? (32'h1 << (b - 32)) : 32'h0);
            cand = '0;
            for (int s = 0; s < 4000; s++) begin
                cand = {8'(s * 53), 8'(s >> 8), 8'(s), 16'(b * 977 + s), 8'h03};
                if (hash_bin(cand) == b) break;
            end
            send(cand, 0, 0, -1, 0, 0, "R4");
            for (int a = 0; a < 6; a++)
                send({8'(a * 53 + b * 7), 8'(a), 24'(a * 1021 + b), 8'h01}, 0, 0, -1, 0, 0, "");
        end

        // disabling and re-enabling an entry (R6)
        wr(0, 32'h0);
        wr(7, {1'b0, 15'd0, EXTRA1[47:32]});
        send(EXTRA1, 0, 0, -1, 0, 0, "R6");
        wr(7, {1'b1, 15'd0, EXTRA1[47:32]});
        send(EXTRA1, 0, 0, -1, 0, 0, "R6");

        // writes during an address (R9)
        send(STRANGR, 0, 0, 2, 0, 32'h1, "R9");
        send(STRANGR, 0, 0, -1, 0, 0, "R9");
        send(STRANGR, 0, 0, 2, 0, 32'h0, "R9");
        send(STRANGR, 0, 0, -1, 0, 0, "R9");
        send(48'h0000_0000_0001, 0, 0, 3, 0, 32'h2, "R9");
        send(48'h0000_0000_0001, 0, 0, -1, 0, 0, "R9");
        wr(0, 32'h0);

        // gaps, trailing bytes, restart (R10)
        send(STATION, 2, 0, -1, 0, 0, "R10");
        send(STRANGR, 1, 0, -1, 0, 0, "R10");
        send(EXTRA1, 0, 5, -1, 0, 0, "R10");
        partial(STRANGR, 3);
        send(STATION, 0, 0, -1, 0, 0, "R10");
        partial(STATION, 4);
        send(STRANGR, 0, 0, -1, 0, 0, "R10");

        done = 1;
        summary();
        $finish;
    end

endmodule